// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point numbers over several clock cycles. A request is given by presenting both operands and an operation select together with a one-cycle `start`. The block then steps through a fixed sequence: it unpacks and orders the operands, aligns the smaller one, adds or subtracts the magnitudes, normalises, and rounds to nearest with ties to even. A one-cycle `done` pulse marks the cycle in which `result` first holds the answer. The result then stays on `result` until the next accepted request.

Operands use the usual packed layout. Bit 31 is the sign, bits 30..23 hold a biased exponent (bias 127), and bits 22..0 hold the fraction, with an implied leading one for normal numbers. An exponent field of zero marks zeros and subnormals. Subnormals have no implied one and a scale of 2^-126. An all-ones exponent field marks infinities (zero fraction) and NaNs (nonzero fraction). The datapath carries a guard bit, a round bit and a sticky bit beyond the 24-bit significand.

Top module: `fp32_addsub`

## Requirements
- R1: For finite operands, `result` is the sum (`subOp`=0) or the difference `opA - opB` (`subOp`=1), rounded to nearest with ties to even and packed as sign bit 31, exponent bits 30..23, fraction bits 22..0.
- R2: If either operand is a NaN (exponent field 255, nonzero fraction), `result` is 0x7FC00000.
- R3: An infinity combined with a finite value gives that infinity, with the sign it carries in the operation. Two infinities of the same effective sign give that infinity. Two infinities that cancel (effective subtraction) give 0x7FC00000.
- R4: When the effective signs differ, that is, different signs on an add or equal signs on a subtract, the magnitudes are subtracted. The result takes the sign of the operand with the larger magnitude.
- R5: Subnormal operands (exponent field 0, nonzero fraction) are used at scale 2^-126 with no implied one. Results below 2^-126 are returned as exact subnormals where they fit, and a subnormal sum that reaches 2^-126 becomes a normal number.
- R6: Ties round to the even fraction. A rounding carry out of the significand increments the exponent and leaves fraction 0.
- R7: A finite result whose rounded magnitude reaches 2^128 becomes an infinity with the result's sign (0x7F800000 or 0xFF800000), never a NaN.
- R8: An exact zero from an effective subtraction is +0. Adding two zeros of the same effective sign keeps that sign, so (-0)+(-0) and (-0)-(+0) give 0x80000000.
- R9: A request is accepted when `start` is high in an idle cycle. `done` is high for exactly one cycle, on the fifth falling edge after the accepting rising edge. `result` holds until the next accepted request. `start` and operand changes while a request is in flight are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled when idle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| subOp | input | 1 | 1 selects opA - opB, 0 selects opA + opB |
| done | output | 1 | One-cycle pulse when result is ready |
| result | output | 32 | Rounded sum or difference |

## Verification
The assertions assume the operands and `subOp` are sampled only on the accepting edge. Under that assumption, the operand values the checker latches at acceptance describe the request that `done` completes. The bench raises `start` only in idle cycles. It applies one extra `start`, together with changed operands, while a request is busy, and expects both to have no effect. All other requests are spaced by the full six-cycle handshake, so the latched operands always belong to the request being completed.

// File: rtl/fp32_addsub_pkg.sv
package fp32_addsub_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int MAN_W   = FRAC_W + 1;        // with hidden bit
  localparam int WORK_W  = MAN_W + 3;         // guard, round, sticky
  localparam int SUM_W   = WORK_W + 1;        // carry out
  localparam int EXPX_W  = EXP_W + 2;
  localparam int LZ_W    = $clog2(WORK_W + 1);
  localparam logic [EXP_W-1:0]  EXP_MAX = {EXP_W{1'b1}};
  localparam logic [WORD_W-1:0] QNAN    = {1'b0, EXP_MAX, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic load;
    logic align;
    logic add;
    logic norm;
    logic round;
  } stepStrobes_t;
endpackage

// File: rtl/fp32_addsub_ctrl.sv
module fp32_addsub_ctrl
  import fp32_addsub_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  output stepStrobes_t steps,
  output logic         done,
  output logic         busy
);
  typedef enum logic [2:0] {S_IDLE, S_ALIGN, S_ADD, S_NORM, S_ROUND, S_DONE} ctlState_t;
  ctlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      S_IDLE:  if (start) stateNext = S_ALIGN;
      S_ALIGN: stateNext = S_ADD;
      S_ADD:   stateNext = S_NORM;
      S_NORM:  stateNext = S_ROUND;
      S_ROUND: stateNext = S_DONE;
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    steps.load  = (state == S_IDLE) && start;
    steps.align = (state == S_ALIGN);
    steps.add   = (state == S_ADD);
    steps.norm  = (state == S_NORM);
    steps.round = (state == S_ROUND);
  end

  assign done = (state == S_DONE);
  assign busy = (state != S_IDLE);
endmodule

// File: rtl/fp32_addsub_dp.sv
module fp32_addsub_dp
  import fp32_addsub_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  stepStrobes_t      steps,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic              subOp,
  output logic [WORD_W-1:0] result
);
  logic [WORD_W-1:0] aReg, bReg;
  logic              subReg;
  // stage state
  logic              sgnR, effSubR, specR;
  logic [WORD_W-1:0] specValR;
  logic [EXPX_W-1:0] expR;
  logic [WORK_W-1:0] bigManR, smallManR, manR;
  logic [SUM_W-1:0]  sumR;

  // ---------------- unpack / order / align ----------------
  logic              signA, signB, swap, effSub, bigSign;
  logic [WORD_W-1:0] bigW, smallW;
  logic [EXP_W-1:0]  bigExpEff, smallExpEff, diff;
  logic [WORK_W-1:0] bigMan, smallMan, smallShift, lostMask, alignedSmall;
  logic              aNan, bNan, aInf, bInf;

  always_comb begin
    signA       = aReg[WORD_W-1];
    signB       = bReg[WORD_W-1] ^ subReg;
    swap        = bReg[WORD_W-2:0] > aReg[WORD_W-2:0];
    bigW        = swap ? bReg : aReg;
    smallW      = swap ? aReg : bReg;
    bigSign     = swap ? signB : signA;
    effSub      = signA ^ signB;
    bigExpEff   = (bigW[WORD_W-2:FRAC_W] == '0) ? EXP_W'(1) : bigW[WORD_W-2:FRAC_W];
    smallExpEff = (smallW[WORD_W-2:FRAC_W] == '0) ? EXP_W'(1) : smallW[WORD_W-2:FRAC_W];
    bigMan      = {(bigW[WORD_W-2:FRAC_W] != '0), bigW[FRAC_W-1:0], 3'b000};
    smallMan    = {(smallW[WORD_W-2:FRAC_W] != '0), smallW[FRAC_W-1:0], 3'b000};
    diff        = bigExpEff - smallExpEff;
    smallShift  = smallMan >> diff;
    lostMask    = ~({WORK_W{1'b1}} << diff);
    if (diff >= EXP_W'(WORK_W))
      alignedSmall = {{(WORK_W-1){1'b0}}, |smallMan};
    else
      alignedSmall = {smallShift[WORK_W-1:1], smallShift[0] | (|(smallMan & lostMask))};
    aNan = (aReg[WORD_W-2:FRAC_W] == EXP_MAX) && (aReg[FRAC_W-1:0] != '0);
    bNan = (bReg[WORD_W-2:FRAC_W] == EXP_MAX) && (bReg[FRAC_W-1:0] != '0);
    aInf = (aReg[WORD_W-2:FRAC_W] == EXP_MAX) && (aReg[FRAC_W-1:0] == '0);
    bInf = (bReg[WORD_W-2:FRAC_W] == EXP_MAX) && (bReg[FRAC_W-1:0] == '0);
  end

  // ---------------- normalise helpers ----------------
  logic [LZ_W-1:0]   lz;
  logic [EXPX_W-1:0] expM1, normShift;

  always_comb begin
    lz = LZ_W'(WORK_W);
    for (int i = 0; i < WORK_W; i++)
      if (sumR[i]) lz = LZ_W'(WORK_W - 1 - i);
    expM1     = expR - EXPX_W'(1);
    normShift = (EXPX_W'(lz) < expM1) ? EXPX_W'(lz) : expM1;
  end

  // ---------------- round helpers ----------------
  logic              roundUp;
  logic [MAN_W:0]    rounded;
  logic [EXPX_W-1:0] expFin;
  logic [MAN_W-1:0]  mantFin;
  logic [EXP_W-1:0]  expField;
  logic [WORD_W-1:0] packed_w;

  always_comb begin
    roundUp  = manR[2] & (manR[1] | manR[0] | manR[3]);
    rounded  = {1'b0, manR[WORK_W-1:3]} + (MAN_W+1)'(roundUp);
    expFin   = rounded[MAN_W] ? expR + EXPX_W'(1) : expR;
    mantFin  = rounded[MAN_W] ? rounded[MAN_W:1] : rounded[MAN_W-1:0];
    expField = mantFin[MAN_W-1] ? expFin[EXP_W-1:0] : '0;
    if (specR)
      packed_w = specValR;
    else if (expFin >= EXPX_W'(EXP_MAX))
      packed_w = {sgnR, EXP_MAX, {FRAC_W{1'b0}}};
    else
      packed_w = {sgnR, expField, mantFin[FRAC_W-1:0]};
  end

  // ---------------- stage registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aReg <= '0; bReg <= '0; subReg <= 1'b0;
      sgnR <= 1'b0; effSubR <= 1'b0; specR <= 1'b0; specValR <= '0;
      expR <= '0; bigManR <= '0; smallManR <= '0; sumR <= '0; manR <= '0;
      result <= '0;
    end else begin
      if (steps.load) begin
        aReg <= opA; bReg <= opB; subReg <= subOp;
      end
      if (steps.align) begin
        sgnR      <= bigSign;
        effSubR   <= effSub;
        expR      <= EXPX_W'(bigExpEff);
        bigManR   <= bigMan;
        smallManR <= alignedSmall;
        specR     <= aNan | bNan | aInf | bInf;
        specValR  <= (aNan | bNan | (aInf & bInf & effSub)) ? QNAN
                   : {bigSign, EXP_MAX, {FRAC_W{1'b0}}};
      end
      if (steps.add)
        sumR <= effSubR ? {1'b0, bigManR} - {1'b0, smallManR}
                        : {1'b0, bigManR} + {1'b0, smallManR};
      if (steps.norm) begin
        if (sumR == '0 && effSubR) sgnR <= 1'b0;
        if (sumR[SUM_W-1]) begin
          manR <= {sumR[SUM_W-1:2], |sumR[1:0]};
          expR <= expR + EXPX_W'(1);
        end else begin
          manR <= sumR[WORK_W-1:0] << normShift;
          expR <= expR - normShift;
        end
      end
      if (steps.round) result <= packed_w;
    end
  end
endmodule

// File: rtl/fp32_addsub.sv
module fp32_addsub
  import fp32_addsub_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic        subOp,
  output logic        done,
  output logic [31:0] result
);
  stepStrobes_t steps;
  logic         busy;

  fp32_addsub_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .steps(steps), .done(done), .busy(busy)
  );

  fp32_addsub_dp u_dp (
    .clk(clk), .rst_n(rst_n), .steps(steps),
    .opA(opA), .opB(opB), .subOp(subOp), .result(result)
  );
endmodule

// File: rtl/fp32_addsub_chk.sv
module fp32_addsub_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] opA,
  input logic [31:0] opB,
  input logic        subOp,
  input logic [31:0] result
);
  logic [31:0] capA, capB;
  logic        capSub;
  logic [2:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capA <= '0; capB <= '0; capSub <= 1'b0; cnt <= '0;
    end else if (start && !busy) begin
      capA <= opA; capB <= opB; capSub <= subOp; cnt <= '0;
    end else if (busy && cnt != 3'd7) begin
      cnt <= cnt + 3'd1;
    end
  end

  logic capNan, capInfCancel, capFinite, bothZero, resNan;
  always_comb begin
    capNan       = ((&capA[30:23]) && (|capA[22:0])) || ((&capB[30:23]) && (|capB[22:0]));
    capInfCancel = (capA[30:0] == 31'h7F800000) && (capB[30:0] == 31'h7F800000)
                   && (capA[31] != (capB[31] ^ capSub));
    capFinite    = !(&capA[30:23]) && !(&capB[30:23]);
    bothZero     = (capA[30:0] == '0) && (capB[30:0] == '0);
    resNan       = (&result[30:23]) && (|result[22:0]);
  end

  // R9: done lasts one cycle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R9: fixed latency from acceptance
  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n) done |-> cnt == 3'd4);
  // R9: result held while idle
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && !$past(start)) |-> $stable(result));
  // R2: NaN in, canonical NaN out
  a_r2_nan_out: assert property (@(posedge clk) disable iff (!rst_n)
    (done && capNan) |-> result == 32'h7FC00000);
  // R3: cancelling infinities
  a_r3_inf_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    (done && capInfCancel) |-> result == 32'h7FC00000);
  // R7: finite operands never give NaN
  a_r7_no_nan: assert property (@(posedge clk) disable iff (!rst_n)
    (done && capFinite) |-> !resNan);
  // R8: sign of a zero sum of zeros
  a_r8_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (done && bothZero) |-> result == {capA[31] & (capB[31] ^ capSub), 31'b0});
endmodule

bind fp32_addsub fp32_addsub_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .opA(opA), .opB(opB), .subOp(subOp), .result(result)
);

// File: tb/fp32_addsub_tb.sv
module fp32_addsub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        subOp = 1'b0;
  logic        done;
  logic [31:0] result;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  fp32_addsub u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opA(opA), .opB(opB),
    .subOp(subOp), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // exact magnitude in units of 2^-149
  function automatic logic [299:0] magOf(input logic [31:0] x);
    logic [299:0] m;
    m = '0;
    m[23:0] = {(x[30:23] != 0), x[22:0]};
    if (x[30:23] != 0) m = m << (x[30:23] - 1);
    return m;
  endfunction

  function automatic logic [31:0] refAdd(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic sa, sb, sr, nanA, nanB, infA, infB;
    logic [299:0] ma, mb, m;
    int p, sh;
    logic [24:0] kept;
    logic g, rest;
    sa = a[31]; sb = b[31] ^ s;
    nanA = (a[30:23] == 8'hFF) && (a[22:0] != 0);
    nanB = (b[30:23] == 8'hFF) && (b[22:0] != 0);
    infA = (a[30:23] == 8'hFF) && (a[22:0] == 0);
    infB = (b[30:23] == 8'hFF) && (b[22:0] == 0);
    if (nanA || nanB) return 32'h7FC00000;
    if (infA && infB) return (sa == sb) ? {sa, 31'h7F800000} : 32'h7FC00000;
    if (infA) return {sa, 31'h7F800000};
    if (infB) return {sb, 31'h7F800000};
    ma = magOf(a); mb = magOf(b);
    if (sa == sb)      begin m = ma + mb; sr = sa; end
    else if (ma >= mb) begin m = ma - mb; sr = sa; end
    else               begin m = mb - ma; sr = sb; end
    if (m == 0) return {(sa == sb) ? sa : 1'b0, 31'b0};
    p = 0;
    for (int i = 0; i < 300; i++) if (m[i]) p = i;
    if (p <= 23) return {sr, m[30:0]};
    sh   = p - 23;
    kept = 25'(m >> sh);
    g    = m[sh-1];
    rest = (m & ((300'b1 << (sh - 1)) - 300'b1)) != 0;
    if (g && (rest || kept[0])) kept = kept + 25'd1;
    if (kept[24]) begin kept = kept >> 1; sh++; end
    if (sh + 1 >= 255) return {sr, 31'h7F800000};
    return {sr, 8'(sh + 1), kept[22:0]};
  endfunction

  // One request: done expected on the 5th falling edge, result held on the 6th.
  task automatic runOp(input logic [31:0] a, input logic [31:0] b, input logic s,
                       input bit junk, input string tag);
    logic [31:0] exp;
    exp = refAdd(a, b, s);
    opA = a; opB = b; subOp = s; start = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      chk(done == (k == 5), "R9 done timing", {31'b0, done}, {31'b0, (k == 5)});
      if (k == 5) chk(result == exp, tag, result, exp);
      if (k == 6) chk(result == exp, {tag, " R9 held"}, result, exp);
      if (k == 1) begin
        start = junk;
        if (junk) begin opA = ~a; opB = 32'h3F800000; subOp = ~s; end
      end
      if (k == 2) start = 1'b0;
    end
  endtask

  function automatic logic [31:0] xs(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && result == 32'h0, "R9 reset state", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 plain sums
    runOp(32'h3F800000, 32'h40000000, 1'b0, 0, "R1 1+2");
    runOp(32'h3EAAAAAB, 32'h3F2AAAAB, 1'b0, 0, "R1 thirds");
    runOp(32'h42F6E979, 32'hC1200000, 1'b1, 0, "R1 sub neg");
    // R4 effective subtract
    runOp(32'h40400000, 32'h3F800000, 1'b1, 0, "R4 3-1");
    runOp(32'h3F800000, 32'hC0200000, 1'b0, 0, "R4 1+(-2.5)");
    runOp(32'h3F800001, 32'h3F800000, 1'b1, 0, "R4 cancel");
    // R5 subnormals
    runOp(32'h00000001, 32'h00000001, 1'b0, 0, "R5 tiny+tiny");
    runOp(32'h00800000, 32'h00000001, 1'b1, 0, "R5 to subnormal");
    runOp(32'h007FFFFF, 32'h00000001, 1'b0, 0, "R5 to normal");
    runOp(32'h80400000, 32'h00100000, 1'b0, 0, "R5 mixed sign");
    // R6 rounding
    runOp(32'h3F800000, 32'h33800000, 1'b0, 0, "R6 tie even");
    runOp(32'h3F800001, 32'h33800000, 1'b0, 0, "R6 tie odd");
    runOp(32'h3FFFFFFF, 32'h33800000, 1'b0, 0, "R6 carry renorm");
    runOp(32'h3F800000, 32'h00000001, 1'b1, 0, "R6 far sticky");
    runOp(32'h3F800000, 32'h33800001, 1'b1, 0, "R6 above half");
    // R7 overflow
    runOp(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 0, "R7 pos ovf");
    runOp(32'hFF7FFFFF, 32'h7F7FFFFF, 1'b1, 0, "R7 neg ovf");
    runOp(32'h7F7FFFFF, 32'h73000000, 1'b0, 0, "R7 round ovf");
    // R2 NaN
    runOp(32'h7FC00000, 32'h3F800000, 1'b0, 0, "R2 nan a");
    runOp(32'h3F800000, 32'hFF800001, 1'b1, 0, "R2 nan b");
    // R3 infinities
    runOp(32'h7F800000, 32'h3F800000, 1'b0, 0, "R3 inf+1");
    runOp(32'h7F800000, 32'h7F800000, 1'b1, 0, "R3 inf-inf");
    runOp(32'hFF800000, 32'h7F800000, 1'b0, 0, "R3 -inf+inf");
    runOp(32'h7F800000, 32'h7F800000, 1'b0, 0, "R3 inf+inf");
    runOp(32'h3F800000, 32'h7F800000, 1'b1, 0, "R3 1-inf");
    // R8 zeros
    runOp(32'h80000000, 32'h80000000, 1'b0, 0, "R8 -0+-0");
    runOp(32'h00000000, 32'h80000000, 1'b0, 0, "R8 +0+-0");
    runOp(32'h80000000, 32'h00000000, 1'b1, 0, "R8 -0-+0");
    runOp(32'h3F800000, 32'h3F800000, 1'b1, 0, "R8 x-x");
    runOp(32'hBF800000, 32'h3F800000, 1'b0, 0, "R8 -x+x");
    runOp(32'h00000000, 32'hC0490FDB, 1'b0, 0, "R8 0+x");
    // R9 stray start and operand change while busy
    runOp(32'h40490FDB, 32'h402DF854, 1'b0, 1, "R9 busy ignore");

    // R1 random mix, plus near-cancellation pairs
    begin
      logic [31:0] st = 32'h1234ABCD;
      for (int n = 0; n < 300; n++) begin
        logic [31:0] a, b;
        st = xs(st); a = st;
        st = xs(st);
        if (n % 3 == 0) b = {~a[31], a[30:8], st[7:0]};
        else if (n % 3 == 1) b = {st[31], a[30:23] - {5'b0, st[2:0]}, st[22:0]};
        else b = st;
        runOp(a, b, st[9], 0, "R1 random");
      end
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL R9 watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule